// File: doc/BRIEF.md
# IPv4 receive frame parser

This block sits behind an Ethernet receive MAC. It takes the received frame one byte per clock on a valid/ready/last byte stream. It walks the 14-byte Ethernet header and the fixed 20-byte IPv4 header with a byte cursor. It keeps a frame only when both of these hold:
- the destination MAC equals the configured local MAC, or is broadcast;
- the destination IPv4 address equals the configured local address.

For a kept frame, the header summary appears together with the first payload byte, and the payload then streams out at wire rate. The summary holds the protocol byte, the source address and the payload length, which is the total length field minus 20. The block stores no frame.

The input never sees back-pressure. `in_ready` rises on the first clock edge after reset is released and then stays high, so every byte with `in_valid` high is consumed on that edge. The payload side has no ready: the consumer must take every byte that `out_valid` marks. Gaps in `in_valid` pass through to the output as gaps in `out_valid`.

The block does not check the header checksum, IP options or fragments. A frame with type 0x0806 gets a one-cycle `arp_frame` pulse so that a neighbouring block can claim it. The parser itself then drops that frame. An accepted-packet counter wraps; a frame error counter saturates and comes with a last error code.

Top module: `ipv4_rx_parser`

## Requirements
- R1: After reset, every output is zero. `in_ready` is high from the first clock edge after reset is released, and stays high.
- R2: For a frame that is kept, the cycle after the first payload byte (frame byte 34) is consumed shows `hdr_valid`, `rx_start` and `out_valid` all high. In that cycle, `hdr_protocol` holds frame byte 23 and `hdr_src_ip` holds frame bytes 26..29, most significant byte first. `hdr_length` holds the total length field (frame bytes 16..17, big-endian) minus 20. A well formed frame leaves `err_count` and `err_code` unchanged.
- R3: Payload bytes appear on `out_data` in arrival order, one cycle after they are consumed. Each cycle without `in_valid` gives a cycle without `out_valid`. `out_last` is high only with the byte that carried `in_last`. In the next cycle, `out_valid`, `out_last` and `rx_start` are all low.
- R4: A destination MAC of all ones (broadcast) is accepted in the same way as the local MAC, when `BCAST_EN` is 1.
- R5: A destination MAC that matches neither the local MAC nor broadcast drops the frame silently until `in_last`. There is no output byte and no change to `pkt_count`, `err_count` or `err_code`.
- R6: A destination IP (frame bytes 30..33) that differs from `local_ip` drops the frame silently, in the same way as R5.
- R7: Only a type of 0x0800 (frame bytes 12..13) is parsed. A type of 0x0806 raises `arp_frame` for exactly one cycle, right after byte 13 is consumed, and is otherwise dropped silently. Any other type is dropped silently with no pulse.
- R8: A first IPv4 byte (frame byte 14) other than 0x45 drops the frame. It also adds one to `err_count` and sets `err_code` to 3.
- R9: When `in_last` arrives on a frame not yet dropped, before any payload byte, the frame is an error. `err_count` goes up by one. `err_code` becomes 1 if the last byte was at position 0..13, and 2 if it was at position 14..33.
- R10: `pkt_count` goes up by one on each `rx_start` and wraps modulo 2^`CNT_W`.
- R11: `err_count` saturates at all ones.
- R12: `hdr_valid` and the header fields hold after a kept frame ends. `hdr_valid` falls in the cycle after the first byte of the next frame is consumed. The fields are replaced only by the next kept frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_mac | input | 48 | Local station MAC, first byte on the wire in bits 47:40 |
| local_ip | input | 32 | Local IPv4 address, first byte in bits 31:24 |
| in_data | input | 8 | Received frame byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Parser takes a byte on each edge where `in_valid` is high |
| in_last | input | 1 | Final byte of the frame |
| hdr_valid | output | 1 | Header summary belongs to the most recently kept frame |
| hdr_protocol | output | 8 | IPv4 protocol byte |
| hdr_length | output | 16 | Payload length, total length minus 20 |
| hdr_src_ip | output | 32 | IPv4 source address |
| rx_start | output | 1 | Pulse with the first payload byte |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | `out_data` holds a payload byte |
| out_last | output | 1 | Final payload byte |
| pkt_count | output | CNT_W | Kept frames, wrapping |
| err_count | output | CNT_W | Frame errors, saturating |
| err_code | output | ERR_W | Last error: 1 short Ethernet header, 2 short IPv4 header, 3 bad version byte |
| arp_frame | output | 1 | One-cycle pulse when type 0x0806 is seen |

## Verification
The bench builds the parser with `CNT_W` set to 4 and `BCAST_EN` left at 1. A 4-bit width lets about twenty short frames carry the packet counter through its wrap and the error counter into saturation. With the default 8-bit width, those corners would need hundreds of frames. Keeping broadcast enabled means the broadcast matcher instance is the variant under test, next to the local-address matchers.

// File: rtl/ipv4_rx_pkg.sv
`timescale 1ns/1ps
package ipv4_rx_pkg;
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_PAY  = 2'd1,
    ST_DROP = 2'd2
  } rx_state_t;

  localparam int ETH_HDR_BYTES = 14;
  localparam int IP_HDR_BYTES  = 20;
  localparam int HDR_BYTES     = ETH_HDR_BYTES + IP_HDR_BYTES;

  localparam int POS_DMAC_FIRST = 0;
  localparam int POS_DMAC_END   = 5;
  localparam int POS_TYPE_HI    = 12;
  localparam int POS_TYPE_LO    = 13;
  localparam int POS_VER        = 14;
  localparam int POS_TLEN_HI    = 16;
  localparam int POS_TLEN_LO    = 17;
  localparam int POS_PROTO      = 23;
  localparam int POS_SIP_FIRST  = 26;
  localparam int POS_SIP_LAST   = 29;
  localparam int POS_DIP_FIRST  = 30;
  localparam int POS_DIP_END    = 33;

  localparam logic [7:0] ETYPE_HI     = 8'h08;
  localparam logic [7:0] ETYPE_IP_LO  = 8'h00;
  localparam logic [7:0] ETYPE_ARP_LO = 8'h06;
  localparam logic [7:0] VER_IHL      = 8'h45;

  localparam int ERR_SHORT_ETH = 1;
  localparam int ERR_SHORT_IP  = 2;
  localparam int ERR_BAD_VER   = 3;
endpackage

// File: rtl/ipv4_rx_cursor.sv
`timescale 1ns/1ps
module ipv4_rx_cursor #(
  parameter int LIMIT = 34,
  localparam int PW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clear,
  output logic [PW-1:0] pos
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pos <= '0;
    else if (clear)                     pos <= '0;
    else if (step && pos < PW'(LIMIT))  pos <= pos + 1'b1;
  end
endmodule

// File: rtl/ipv4_rx_addr_match.sv
`timescale 1ns/1ps
module ipv4_rx_addr_match #(
  parameter int NB   = 6,
  parameter int BASE = 0,
  parameter int PW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NB*8-1:0] key,
  input  logic [PW-1:0]   pos,
  input  logic            byte_en,
  input  logic [7:0]      data,
  output logic            hit
);
  logic       ok_q;
  logic       in_win;
  logic [7:0] sel;
  logic       eq;

  always_comb begin
    in_win = 1'b0;
    sel    = '0;
    for (int k = 0; k < NB; k++) begin
      if (pos == PW'(BASE + k)) begin
        in_win = 1'b1;
        sel    = key[(NB-1-k)*8 +: 8];
      end
    end
    eq  = (sel == data);
    hit = byte_en && (pos == PW'(BASE + NB - 1)) && ok_q && eq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else if (byte_en && in_win)
      ok_q <= (pos == PW'(BASE)) ? eq : (ok_q && eq);
  end
endmodule

// File: rtl/ipv4_rx_err_track.sv
`timescale 1ns/1ps
module ipv4_rx_err_track #(
  parameter int CNT_W = 8,
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [ERR_W-1:0] code_in,
  output logic [CNT_W-1:0] count,
  output logic [ERR_W-1:0] code
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      code  <= '0;
    end else if (fire) begin
      code <= code_in;
      if (count != CNT_MAX) count <= count + 1'b1;
    end
  end

  AST_ERR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX) |=> (count == CNT_MAX)); // R11
  AST_ERR_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (code != '0)); // R9
endmodule

// File: rtl/ipv4_rx_parser.sv
`timescale 1ns/1ps
module ipv4_rx_parser
  import ipv4_rx_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int ERR_W    = 4,
  parameter bit BCAST_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [47:0]      local_mac,
  input  logic [31:0]      local_ip,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_last,
  output logic             hdr_valid,
  output logic [7:0]       hdr_protocol,
  output logic [15:0]      hdr_length,
  output logic [31:0]      hdr_src_ip,
  output logic             rx_start,
  output logic [7:0]       out_data,
  output logic             out_valid,
  output logic             out_last,
  output logic [CNT_W-1:0] pkt_count,
  output logic [CNT_W-1:0] err_count,
  output logic [ERR_W-1:0] err_code,
  output logic             arp_frame
);
  localparam int PW = $clog2(HDR_BYTES + 1);

  rx_state_t        st_q, st_d;
  logic             byte_ok, hdr_byte, pay_byte, first_q;
  logic [PW-1:0]    pos;
  logic             mac_hit, bc_hit, ip_hit;
  logic             drop_now, accept_now, err_now, arp_now;
  logic [ERR_W-1:0] err_code_d;
  logic [15:0]      tlen_sh;
  logic [7:0]       proto_sh;
  logic [31:0]      sip_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign byte_ok  = in_valid && in_ready;
  assign hdr_byte = byte_ok && (st_q == ST_HDR);
  assign pay_byte = byte_ok && (st_q == ST_PAY);

  ipv4_rx_cursor #(.LIMIT(HDR_BYTES)) u_cursor (
    .clk(clk), .rst_n(rst_n), .step(hdr_byte),
    .clear(byte_ok && in_last), .pos(pos)
  );

  ipv4_rx_addr_match #(.NB(6), .BASE(POS_DMAC_FIRST), .PW(PW)) u_mac_match (
    .clk(clk), .rst_n(rst_n), .key(local_mac), .pos(pos),
    .byte_en(hdr_byte), .data(in_data), .hit(mac_hit)
  );

  generate
    if (BCAST_EN) begin : g_bcast
      ipv4_rx_addr_match #(.NB(6), .BASE(POS_DMAC_FIRST), .PW(PW)) u_bc_match (
        .clk(clk), .rst_n(rst_n), .key({6{8'hFF}}), .pos(pos),
        .byte_en(hdr_byte), .data(in_data), .hit(bc_hit)
      );
    end else begin : g_no_bcast
      assign bc_hit = 1'b0;
    end
  endgenerate

  ipv4_rx_addr_match #(.NB(4), .BASE(POS_DIP_FIRST), .PW(PW)) u_ip_match (
    .clk(clk), .rst_n(rst_n), .key(local_ip), .pos(pos),
    .byte_en(hdr_byte), .data(in_data), .hit(ip_hit)
  );

  ipv4_rx_err_track #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .fire(err_now), .code_in(err_code_d),
    .count(err_count), .code(err_code)
  );

  // Header decisions, one per byte position, made on the byte being consumed.
  always_comb begin
    drop_now   = 1'b0;
    accept_now = 1'b0;
    err_now    = 1'b0;
    arp_now    = 1'b0;
    err_code_d = '0;
    if (hdr_byte) begin
      case (pos)
        PW'(POS_DMAC_END): if (!(mac_hit || bc_hit)) drop_now = 1'b1;
        PW'(POS_TYPE_HI):  if (in_data != ETYPE_HI) drop_now = 1'b1;
        PW'(POS_TYPE_LO): begin
          if (in_data == ETYPE_ARP_LO) begin
            arp_now  = 1'b1;
            drop_now = 1'b1;
          end else if (in_data != ETYPE_IP_LO) begin
            drop_now = 1'b1;
          end
        end
        PW'(POS_VER): if (in_data != VER_IHL) begin
          err_now    = 1'b1;
          err_code_d = ERR_W'(ERR_BAD_VER);
          drop_now   = 1'b1;
        end
        PW'(POS_DIP_END): if (ip_hit) accept_now = 1'b1; else drop_now = 1'b1;
        default: ;
      endcase
      if (in_last && !drop_now) begin
        accept_now = 1'b0;
        err_now    = 1'b1;
        err_code_d = (pos < PW'(ETH_HDR_BYTES)) ? ERR_W'(ERR_SHORT_ETH)
                                                : ERR_W'(ERR_SHORT_IP);
      end
    end
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_HDR: if (byte_ok && !in_last) begin
        if (drop_now)        st_d = ST_DROP;
        else if (accept_now) st_d = ST_PAY;
      end
      default: if (byte_ok && in_last) st_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_HDR;
      first_q  <= 1'b0;
      tlen_sh  <= '0;
      proto_sh <= '0;
      sip_sh   <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_HDR && st_d == ST_PAY) first_q <= 1'b1;
      else if (pay_byte)                    first_q <= 1'b0;
      if (hdr_byte) begin
        if (pos == PW'(POS_TLEN_HI)) tlen_sh[15:8] <= in_data;
        if (pos == PW'(POS_TLEN_LO)) tlen_sh[7:0]  <= in_data;
        if (pos == PW'(POS_PROTO))   proto_sh      <= in_data;
        if (pos >= PW'(POS_SIP_FIRST) && pos <= PW'(POS_SIP_LAST))
          sip_sh <= {sip_sh[23:0], in_data};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_valid    <= 1'b0;
      hdr_protocol <= '0;
      hdr_length   <= '0;
      hdr_src_ip   <= '0;
      rx_start     <= 1'b0;
      out_data     <= '0;
      out_valid    <= 1'b0;
      out_last     <= 1'b0;
      pkt_count    <= '0;
      arp_frame    <= 1'b0;
    end else begin
      out_valid <= pay_byte;
      out_last  <= pay_byte && in_last;
      rx_start  <= pay_byte && first_q;
      arp_frame <= arp_now;
      if (pay_byte) out_data <= in_data;
      if (pay_byte && first_q) begin
        hdr_valid    <= 1'b1;
        hdr_protocol <= proto_sh;
        hdr_length   <= tlen_sh - 16'(IP_HDR_BYTES);
        hdr_src_ip   <= sip_sh;
        pkt_count    <= pkt_count + 1'b1;
      end else if (hdr_byte && pos == '0) begin
        hdr_valid <= 1'b0;
      end
    end
  end

  AST_START_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |-> (out_valid && hdr_valid)); // R2
  AST_LAST_THEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> (!out_valid && !out_last && !rx_start)); // R3
  AST_ARP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    arp_frame |=> !arp_frame); // R7
  AST_PKT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |-> (pkt_count == $past(pkt_count) + 1'b1)); // R10
  AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_start |-> $stable(pkt_count)); // R10
  AST_HDR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_valid) |-> rx_start); // R12
endmodule

// File: tb/ipv4_rx_parser_bench.sv
`timescale 1ns/1ps
module ipv4_rx_parser_bench;
  localparam int CW = 4;
  localparam logic [47:0] LMAC = 48'h02_0A_0B_0C_0D_0E;
  localparam logic [31:0] LIP  = 32'h0A_01_02_03;
  localparam logic [31:0] SIP  = 32'hC0_A8_07_21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic in_ready, hdr_valid, rx_start, out_valid, out_last, arp_frame;
  logic [7:0] hdr_protocol, out_data;
  logic [15:0] hdr_length;
  logic [31:0] hdr_src_ip;
  logic [CW-1:0] pkt_count, err_count;
  logic [3:0] err_code;

  always #2 clk = ~clk;

  ipv4_rx_parser #(.CNT_W(CW), .ERR_W(4), .BCAST_EN(1'b1)) u_ipv4_rx_parser (
    .clk(clk), .rst_n(rst_n), .local_mac(LMAC), .local_ip(LIP),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
    .hdr_valid(hdr_valid), .hdr_protocol(hdr_protocol), .hdr_length(hdr_length),
    .hdr_src_ip(hdr_src_ip), .rx_start(rx_start), .out_data(out_data),
    .out_valid(out_valid), .out_last(out_last), .pkt_count(pkt_count),
    .err_count(err_count), .err_code(err_code), .arp_frame(arp_frame)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int exp_pkt = 0, exp_err = 0;

  logic [7:0] fb [0:63];
  int fl;
  int nvalid, bad;
  logic s_hv, s_rs, s_ov, s_hv0, s_arp13, s_arp14, s_quiet;
  logic [7:0] s_proto, s_proto0;
  logic [15:0] s_len;
  logic [31:0] s_sip;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic mk_frame(input logic [47:0] dmac, input logic [15:0] et,
                          input logic [7:0] ver, input int npay, input logic [7:0] proto,
                          input logic [31:0] dip, input logic [7:0] pbase);
    logic [15:0] tl;
    tl = 16'(20 + npay);
    for (int k = 0; k < 6; k++) fb[k] = dmac[(5-k)*8 +: 8];
    for (int k = 0; k < 6; k++) fb[6+k] = 8'h30 + 8'(k);
    fb[12] = et[15:8]; fb[13] = et[7:0];
    fb[14] = ver; fb[15] = 8'h00; fb[16] = tl[15:8]; fb[17] = tl[7:0];
    fb[18] = 8'h12; fb[19] = 8'h34; fb[20] = 8'h00; fb[21] = 8'h00;
    fb[22] = 8'h40; fb[23] = proto; fb[24] = 8'hBE; fb[25] = 8'hEF;
    for (int k = 0; k < 4; k++) fb[26+k] = SIP[(3-k)*8 +: 8];
    for (int k = 0; k < 4; k++) fb[30+k] = dip[(3-k)*8 +: 8];
    for (int k = 0; k < npay; k++) fb[34+k] = pbase + 8'(k);
    fl = 34 + npay;
  endtask

  // Sends fb[0..fl-1]; outputs for byte i are sampled at the negedge after it.
  task automatic send_frame(input bit deliver, input bit gap);
    nvalid = 0; bad = 0;
    for (int i = 0; i < fl; i++) begin
      in_data = fb[i]; in_valid = 1'b1; in_last = (i == fl - 1);
      @(negedge clk);
      if (out_valid) begin
        nvalid++;
        if (!deliver || i < 34 || out_data != fb[i]) bad++;
      end
      if (out_last != (deliver && i == fl - 1)) bad++;
      if (i == 0)  begin s_hv0 = hdr_valid; s_proto0 = hdr_protocol; end
      if (i == 13) s_arp13 = arp_frame;
      if (i == 14) s_arp14 = arp_frame;
      if (i == 34) begin
        s_hv = hdr_valid; s_rs = rx_start; s_ov = out_valid;
        s_proto = hdr_protocol; s_len = hdr_length; s_sip = hdr_src_ip;
      end else if (rx_start) bad++;
      if (gap && i >= 34 && i < fl - 1) begin
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);
        if (out_valid || rx_start) bad++;
      end
    end
    in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    @(negedge clk);
    s_quiet = !out_valid && !out_last && !rx_start;
  endtask

  task automatic test_reset();
    chk(!hdr_valid && !rx_start && !out_valid && !out_last && !arp_frame, "R1",
        "strobes after reset", {hdr_valid, rx_start, out_valid, out_last, arp_frame}, 0);
    chk(hdr_protocol == 0 && hdr_length == 0 && hdr_src_ip == 0 && out_data == 0, "R1",
        "fields after reset", {hdr_protocol, hdr_length, hdr_src_ip}, 0);
    chk(pkt_count == 0 && err_count == 0 && err_code == 0, "R1",
        "counters after reset", {pkt_count, err_count, err_code}, 0);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
  endtask

  task automatic test_accept();
    mk_frame(LMAC, 16'h0800, 8'h45, 4, 8'h11, LIP, 8'h24);
    send_frame(1'b1, 1'b0);
    exp_pkt++;
    chk(s_hv && s_rs && s_ov, "R2", "first byte strobes", {s_hv, s_rs, s_ov}, 3'b111);
    chk(s_proto == 8'h11, "R2", "protocol", s_proto, 8'h11);
    chk(s_len == 16'd4, "R2", "payload length", s_len, 4);
    chk(s_sip == SIP, "R2", "source ip", s_sip, SIP);
    chk(err_count == 0 && err_code == 0, "R2", "no error", {err_count, err_code}, 0);
    chk(bad == 0 && nvalid == 4, "R3", "payload stream", {bad[15:0], nvalid[15:0]}, 4);
    chk(s_quiet, "R3", "strobes clear after last", s_quiet, 1);
    chk(pkt_count == CW'(exp_pkt), "R10", "packet count", pkt_count, exp_pkt);
    chk(hdr_valid && hdr_protocol == 8'h11, "R12", "header held after frame",
        {hdr_valid, hdr_protocol}, {1'b1, 8'h11});
  endtask

  task automatic test_gap();
    mk_frame(LMAC, 16'h0800, 8'h45, 5, 8'h06, LIP, 8'h80);
    send_frame(1'b1, 1'b1);
    exp_pkt++;
    chk(bad == 0 && nvalid == 5, "R3", "payload with input gaps",
        {bad[15:0], nvalid[15:0]}, 5);
    chk(s_len == 16'd5 && s_rs, "R3", "gapped frame header", s_len, 5);
  endtask

  task automatic test_bcast();
    mk_frame({6{8'hFF}}, 16'h0800, 8'h45, 3, 8'h2F, LIP, 8'h40);
    send_frame(1'b1, 1'b0);
    exp_pkt++;
    chk(bad == 0 && nvalid == 3 && s_rs, "R4", "broadcast delivered",
        {bad[15:0], nvalid[15:0]}, 3);
    chk(pkt_count == CW'(exp_pkt), "R4", "broadcast counted", pkt_count, exp_pkt);
  endtask

  task automatic test_drop(input logic [47:0] dmac, input logic [31:0] dip, input string req);
    mk_frame(dmac, 16'h0800, 8'h45, 3, 8'h11, dip, 8'h10);
    send_frame(1'b0, 1'b0);
    chk(bad == 0 && nvalid == 0, req, "dropped frame output", nvalid, 0);
    chk(pkt_count == CW'(exp_pkt) && err_count == CW'(exp_err), req, "counters unchanged",
        {pkt_count, err_count}, {CW'(exp_pkt), CW'(exp_err)});
  endtask

  task automatic test_hold();
    // Previous kept frame carried protocol 0x2F.
    mk_frame(48'h02_99_99_99_99_99, 16'h0800, 8'h45, 2, 8'h55, LIP, 8'h00);
    send_frame(1'b0, 1'b0);
    chk(!s_hv0 && s_proto0 == 8'h2F, "R12", "hdr_valid falls on next frame",
        {s_hv0, s_proto0}, {1'b0, 8'h2F});
    chk(hdr_protocol == 8'h2F && hdr_length == 16'd3, "R12", "fields held",
        {hdr_protocol, hdr_length}, {8'h2F, 16'd3});
  endtask

  task automatic test_types();
    mk_frame(LMAC, 16'h0806, 8'h00, 4, 8'h00, LIP, 8'h00);
    send_frame(1'b0, 1'b0);
    chk(s_arp13 && !s_arp14, "R7", "arp pulse", {s_arp13, s_arp14}, 2'b10);
    chk(nvalid == 0 && bad == 0 && err_count == CW'(exp_err), "R7", "arp dropped",
        {nvalid[15:0], err_count}, {16'd0, CW'(exp_err)});
    mk_frame(LMAC, 16'h86DD, 8'h60, 4, 8'h00, LIP, 8'h00);
    send_frame(1'b0, 1'b0);
    chk(!s_arp13 && nvalid == 0 && bad == 0 && err_count == CW'(exp_err), "R7",
        "other type dropped", {s_arp13, nvalid[15:0]}, 0);
  endtask

  task automatic test_badver();
    mk_frame(LMAC, 16'h0800, 8'h46, 4, 8'h11, LIP, 8'h00);
    send_frame(1'b0, 1'b0);
    exp_err++;
    chk(err_count == CW'(exp_err) && err_code == 4'd3, "R8", "bad version error",
        {err_count, err_code}, {CW'(exp_err), 4'd3});
    chk(nvalid == 0 && bad == 0, "R8", "bad version no output", nvalid, 0);
  endtask

  task automatic test_trunc(input int len, input logic [3:0] code);
    mk_frame(LMAC, 16'h0800, 8'h45, 4, 8'h11, LIP, 8'h00);
    fl = len;
    send_frame(1'b0, 1'b0);
    if (exp_err < (1 << CW) - 1) exp_err++;
    chk(err_count == CW'(exp_err) && err_code == code, "R9", "truncated frame",
        {err_count, err_code}, {CW'(exp_err), code});
    chk(nvalid == 0 && pkt_count == CW'(exp_pkt), "R9", "truncated no output",
        {nvalid[15:0], pkt_count}, {16'd0, CW'(exp_pkt)});
  endtask

  task automatic test_wrap();
    for (int n = 0; n < 17; n++) begin
      mk_frame(LMAC, 16'h0800, 8'h45, 1, 8'h11, LIP, 8'(n));
      send_frame(1'b1, 1'b0);
      exp_pkt = (exp_pkt + 1) % (1 << CW);
      chk(pkt_count == CW'(exp_pkt), "R10", "packet count wrap", pkt_count, exp_pkt);
    end
  endtask

  task automatic test_sat();
    for (int n = 0; n < 16; n++) begin
      mk_frame(LMAC, 16'h0800, 8'h45, 1, 8'h11, LIP, 8'h00);
      fl = 1;
      send_frame(1'b0, 1'b0);
      if (exp_err < (1 << CW) - 1) exp_err++;
      chk(err_count == CW'(exp_err), "R11", "error count saturation", err_count, exp_err);
    end
    chk(err_count == '1 && err_code == 4'd1, "R11", "saturated value",
        {err_count, err_code}, {{CW{1'b1}}, 4'd1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_accept();
    test_gap();
    test_bcast();
    test_hold();
    test_drop(48'h02_0A_0B_0C_0D_0F, LIP, "R5");
    test_drop(LMAC, 32'h0A_01_02_04, "R6");
    test_types();
    test_badver();
    test_trunc(10, 4'd1);
    test_trunc(20, 4'd2);
    test_trunc(34, 4'd2);
    test_wrap();
    test_sat();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule